// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

One timer channel that drives a single pulse-width-modulated output from a 16-bit up-counter. The counter advances on prescaled ticks. The tick source is either the system clock or a pulse input, `ext_tick`, that is synchronous to the system clock. The prescaler divides that source by 4 raised to a selectable exponent. A small write port loads a control word, the counter value, a duty compare and a period compare. Two separate strobes start and stop the counter.

The counter runs from its current value up to the period compare and then wraps to 0. The output sits at its initial (inactive) level while the count is below the duty compare. It goes active from the duty match until the wrap. A duty compare above the period parks the output at its initial level. A polarity bit inverts both levels. Clearing the output enable returns the output to its initial level in one of two ways: at once (abrupt shutdown) or at the end of the current period. Software can reprogram the channel while the counter is stopped, because writes still land and the count stays frozen.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, `pwm_out` is 0, `count` is 0 and the counter is stopped.
- R2: The prescaler exponent is `wr_data[2:0]` of a control write (select 0). The counter ticks once every 4^n source pulses for n in 0..5, and values 6 and 7 act as 5.
- R3: Control bit 3 picks the tick source. At 1 only cycles with `ext_tick` high count, and at 0 every clock cycle counts.
- R4: A running counter steps by one per tick and wraps to 0 on the tick where it equals the period compare (select 3). The output period is (P+1)·4^n source pulses.
- R5: When 1 ≤ D ≤ P, with D the duty compare (select 2), the output is active for (P−D+1)·4^n source pulses per period and is at its initial level for the rest.
- R6: When the duty compare exceeds the period compare, the output never leaves its initial level.
- R7: With a period compare of 0, the count stays at 0 and the output stays at its initial level.
- R8: Control bit 5 selects active-low. With it clear the initial level is 0 and the active level is 1, and with it set both levels are inverted.
- R9: Control bit 4 enables the output. With abrupt shutdown (control bit 6) set, a write that clears bit 4 puts the output at its initial level within two clocks of the write.
- R10: With abrupt shutdown clear, clearing bit 4 leaves the waveform running until the counter wraps. The output then returns to its initial level.
- R11: The `stop` strobe freezes the count and the prescaler, and `start` resumes counting. `stop` wins when both strobes are high. Register writes take effect while the counter is stopped.
- R12: A write to select 1 loads the count directly, takes priority over a tick, and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External tick pulse, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 count, 2 duty, 3 period |
| wr_data | input | 16 | Write data |
| start | input | 1 | Start counter strobe |
| stop | input | 1 | Stop counter strobe |
| pwm_out | output | 1 | PWM output level |
| count | output | 16 | Current counter value |

## Verification
The assertions assume that `ext_tick` and every strobe are synchronous single-clock signals. They also assume that a count write sets a value no greater than the period whenever the parked-output property is to hold. The bench therefore always stops the channel, clears the count and loads duty and period before the control word and `start`. Random cases draw period, duty and exponent from ranges that satisfy 1 ≤ D ≤ P and keep each period short. The external source is a fixed pulse every third clock, so the expected cycle counts are exact multiples.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_DUTY   = 2'd2,
      SEL_PERIOD = 2'd3
   } reg_sel_e;

   // control word, LSB first: psc_sel[2:0], src_ext[3], out_en[4], act_low[5], abrupt[6]
   typedef struct packed {
      logic       abrupt;
      logic       act_low;
      logic       out_en;
      logic       src_ext;
      logic [2:0] psc_sel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_psc.sv
module pwm_psc #(
   parameter int PSC_MAX = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       src_ext,
   input  logic       ext_tick,
   input  logic [2:0] sel,
   input  logic       clr,
   output logic       tick
);
   localparam int PSC_W = (PSC_MAX == 0) ? 1 : 2 * PSC_MAX;
   localparam int N_SEL = 8;

   logic [PSC_W-1:0] lim [N_SEL];
   logic [PSC_W-1:0] pcnt_q;
   logic             step;
   logic             at_lim;

   // terminal count per select; selects above PSC_MAX saturate
   for (genvar i = 0; i < N_SEL; i++) begin : g_lim
      if (i <= PSC_MAX) begin : g_ok
         assign lim[i] = PSC_W'((1 << (2 * i)) - 1);
      end else begin : g_sat
         assign lim[i] = PSC_W'((1 << (2 * PSC_MAX)) - 1);
      end
   end

   assign step   = run && (src_ext ? ext_tick : 1'b1);
   assign at_lim = (pcnt_q == lim[sel]);
   assign tick   = step && at_lim && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (clr) begin
         pcnt_q <= '0;
      end else if (step) begin
         pcnt_q <= at_lim ? '0 : pcnt_q + PSC_W'(1);
      end
   end

endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign cnt  = cnt_q;
   assign wrap = tick && !ld && (cnt_q == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
      end else if (tick) begin
         cnt_q <= (cnt_q == period) ? '0 : cnt_q + ONE;
      end
   end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] period,
   input  logic             out_en,
   input  logic             act_low,
   input  logic             abrupt,
   input  logic             running,
   input  logic             wrap,
   output logic             gate,
   output logic             pwm
);
   logic gate_q;
   logic pwm_q;
   logic in_active;

   assign in_active = (period != '0) && (duty <= period) && (cnt >= duty);
   assign gate      = gate_q;
   assign pwm       = pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (out_en) begin
         gate_q <= 1'b1;
      end else if (abrupt || !running || wrap) begin
         gate_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         pwm_q <= act_low ^ (gate_q && in_active);
      end
   end

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PSC_MAX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             start,
   input  logic             stop,
   output logic             pwm_out,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < CTRL_W) begin : g_chk_w
      $error("CNT_W must hold the control word");
   end
   if (PSC_MAX < 0 || PSC_MAX > 7) begin : g_chk_psc
      $error("PSC_MAX must lie in 0..7");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] period_q;
   logic             run_q;
   logic             cnt_ld;
   logic             tick;
   logic             wrap;
   logic             gate;
   logic [CNT_W-1:0] cnt;

   assign cnt_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
   assign count  = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         duty_q   <= '0;
         period_q <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
            SEL_DUTY:   duty_q   <= wr_data;
            SEL_PERIOD: period_q <= wr_data;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (stop) begin
         run_q <= 1'b0;
      end else if (start) begin
         run_q <= 1'b1;
      end
   end

   pwm_psc #(.PSC_MAX(PSC_MAX)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .src_ext  (ctrl_q.src_ext),
      .ext_tick (ext_tick),
      .sel      (ctrl_q.psc_sel),
      .clr      (cnt_ld),
      .tick     (tick)
   );

   pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .ld     (cnt_ld),
      .ld_val (wr_data),
      .period (period_q),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   pwm_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .duty    (duty_q),
      .period  (period_q),
      .out_en  (ctrl_q.out_en),
      .act_low (ctrl_q.act_low),
      .abrupt  (ctrl_q.abrupt),
      .running (run_q),
      .wrap    (wrap),
      .gate    (gate),
      .pwm     (pwm_out)
   );

endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_ld,
   input logic             run,
   input logic             tick,
   input logic             gate,
   input logic             out_en,
   input logic             abrupt,
   input logic             act_low,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] duty,
   input logic [CNT_W-1:0] period,
   input logic             pwm_out
);
   // R4: a tick at the period compare wraps the count to 0
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !cnt_ld && cnt == period) |=> (cnt == '0));

   // R7: a zero period holds the count at 0
   a_r7_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 && cnt == '0 && !cnt_ld) |=> (cnt == '0));

   // R11: a stopped counter keeps its value unless loaded
   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_ld) |=> $stable(cnt));

   // R6: duty above period keeps the output at its initial level
   a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (duty > period && cnt <= period) |=> (pwm_out == $past(act_low)));

   // R9: abrupt shutdown closes the output gate on the next clock
   a_r9_abrupt: assert property (@(posedge clk) disable iff (!rst_n)
      (abrupt && !out_en) |=> !gate);

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt_ld  (cnt_ld),
   .run     (run_q),
   .tick    (tick),
   .gate    (gate),
   .out_en  (ctrl_q.out_en),
   .abrupt  (ctrl_q.abrupt),
   .act_low (ctrl_q.act_low),
   .cnt     (cnt),
   .duty    (duty_q),
   .period  (period_q),
   .pwm_out (pwm_out)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;
   localparam int CLK_P = 10;
   localparam int W     = 16;
   localparam int GUARD = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ext_tick = 1'b0;
   logic         ext_on = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = '0;
   logic [W-1:0] wr_data = '0;
   logic         start = 1'b0;
   logic         stop = 1'b0;
   logic         pwm_out;
   logic [W-1:0] count;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   pwm_timer_chan u_dut (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .start(start), .stop(stop),
      .pwm_out(pwm_out), .count(count)
   );

   // external tick: one pulse every third clock when enabled
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph = (ph + 1) % 3;
         ext_tick = ext_on && (ph == 0);
      end
   end

   function automatic int pow4(input int n);
      return 1 << (2 * n);
   endfunction

   function automatic int exp_hi(input int p, input int d, input int n, input int div);
      return (p - d + 1) * pow4(n) * div;
   endfunction

   function automatic int exp_per(input int p, input int n, input int div);
      return (p + 1) * pow4(n) * div;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic wr(input logic [1:0] s, input int v);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = W'(v);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe(input bit go);
      @(negedge clk);
      if (go) start = 1'b1; else stop = 1'b1;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
   endtask

   function automatic int ctrl_word(input int sel, input bit ext, input bit en,
                                    input bit al, input bit ab);
      return sel | (int'(ext) << 3) | (int'(en) << 4) | (int'(al) << 5) | (int'(ab) << 6);
   endfunction

   task automatic cfg(input int sel, input bit ext, input bit en, input bit al,
                      input bit ab, input int d, input int p);
      strobe(1'b0);
      wr(2'd1, 0);
      wr(2'd2, d);
      wr(2'd3, p);
      wr(2'd0, ctrl_word(sel, ext, en, al, ab));
      strobe(1'b1);
   endtask

   // measures one full active segment and the following inactive one
   task automatic measure(input logic lvl, output int hi, output int per);
      int g = 0;
      int lo = 0;
      hi = 0;
      while (pwm_out == lvl && g < GUARD) begin @(negedge clk); g++; end
      while (pwm_out != lvl && g < GUARD) begin @(negedge clk); g++; end
      while (pwm_out == lvl && g < GUARD) begin @(negedge clk); g++; hi++; end
      while (pwm_out != lvl && g < GUARD) begin @(negedge clk); g++; lo++; end
      per = hi + lo;
   endtask

   task automatic run_case(input string req, input int sel, input int n, input bit ext,
                           input bit al, input int d, input int p);
      int hi, per, div;
      div = ext ? 3 : 1;
      ext_on = ext;
      cfg(sel, ext, 1'b1, al, 1'b0, d, p);
      measure(~al, hi, per);
      check(hi == exp_hi(p, d, n, div), {req, " high time"}, hi, exp_hi(p, d, n, div));
      check(per == exp_per(p, n, div), {req, " period"}, per, exp_per(p, n, div));
      ext_on = 1'b0;
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seen, c0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
      check(count == '0, "R1 count after reset", int'(count), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(count == '0, "R1 counter stopped", int'(count), 0);

      // R4 R5 directed, prescaler 0 and 1
      run_case("R4 R5 p7 d3 n0", 0, 0, 1'b0, 1'b0, 3, 7);
      run_case("R4 R5 p4 d1 n1", 1, 1, 1'b0, 1'b0, 1, 4);
      // R2 top prescaler and saturation of selects 6 and 7
      run_case("R2 sel5", 5, 5, 1'b0, 1'b0, 1, 1);
      run_case("R2 sel7 saturates", 7, 5, 1'b0, 1'b0, 1, 1);
      // R3 external source
      run_case("R3 ext source", 0, 0, 1'b1, 1'b0, 2, 5);
      // R8 inverted polarity
      run_case("R8 active low", 1, 1, 1'b0, 1'b1, 2, 6);
      // R5 random cases
      for (int k = 0; k < 6; k++) begin
         int p, d, n;
         p = 1 + int'($urandom_range(19));
         d = 1 + int'($urandom_range(p - 1));
         n = int'($urandom_range(2));
         run_case("R5 random", n, n, 1'b0, k[0], d, p);
      end

      // R6 duty above period
      cfg(0, 1'b0, 1'b1, 1'b0, 1'b0, 11, 10);
      seen = 0;
      repeat (200) begin @(negedge clk); if (pwm_out) seen++; end
      check(seen == 0, "R6 parked output", seen, 0);

      // R7 zero period
      cfg(0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
      seen = 0;
      repeat (40) begin @(negedge clk); if (pwm_out || count != '0) seen++; end
      check(seen == 0, "R7 zero period", seen, 0);

      // R9 abrupt shutdown
      cfg(1, 1'b0, 1'b1, 1'b0, 1'b1, 2, 20);
      seen = 0;
      while (!pwm_out && seen < GUARD) begin @(negedge clk); seen++; end
      wr(2'd0, ctrl_word(1, 1'b0, 1'b0, 1'b0, 1'b1));
      @(negedge clk); @(negedge clk);
      check(pwm_out == 1'b0, "R9 abrupt off", int'(pwm_out), 0);

      // R10 graceful shutdown
      cfg(1, 1'b0, 1'b1, 1'b0, 1'b0, 2, 20);
      seen = 0;
      while (!pwm_out && seen < GUARD) begin @(negedge clk); seen++; end
      wr(2'd0, ctrl_word(1, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); @(negedge clk);
      check(pwm_out == 1'b1, "R10 holds until wrap", int'(pwm_out), 1);
      seen = 0;
      while (count != '0 && seen < GUARD) begin @(negedge clk); seen++; end
      @(negedge clk); @(negedge clk);
      check(pwm_out == 1'b0, "R10 idle after wrap", int'(pwm_out), 0);

      // R11 stop freezes, R12 direct load while stopped
      cfg(0, 1'b0, 1'b1, 1'b0, 1'b0, 3, 200);
      repeat (20) @(negedge clk);
      strobe(1'b0);
      @(negedge clk);
      c0 = int'(count);
      repeat (30) @(negedge clk);
      check(int'(count) == c0, "R11 frozen count", int'(count), c0);
      wr(2'd1, 5);
      check(count == W'(5), "R12 load while stopped", int'(count), 5);
      repeat (5) @(negedge clk);
      check(count == W'(5), "R11 load holds while stopped", int'(count), 5);
      strobe(1'b1);
      repeat (10) @(negedge clk);
      check(count > W'(5), "R11 resumes after start", int'(count), 6);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule